// File: doc/BRIEF.md
# PHY Link Status Resolver

This block works out the present state of an Ethernet link by walking through a fixed series of register reads on a PHY's management registers. It talks to a read engine through a simple request/acknowledge port: it raises a one-cycle read request with an address, then waits for an acknowledge that carries the data word and an error flag. Only one read is in flight at any time. The read engine itself, meaning the serial management framing, is outside this block.

A one-cycle `start` pulse begins a resolution. The block always reads the control register and then the status register. Because the link bit in the status register latches low, a low reading is followed by a second status read. What comes next depends on the operating mode. In forced mode, speed and duplex are taken from the control word. When autonegotiation is enabled and has completed, a vendor auxiliary register supplies speed and duplex. If that result is full duplex, the partner and local ability registers are also read so that the receive and transmit pause settings can be resolved.

At the end of a resolution the block raises `done` for one cycle and presents link up/down, an encoded speed with a valid bit, duplex with a valid bit, the two pause flags and an error flag. These outputs hold steady until the next completion.

Top module: `phy_link_resolver`

## Requirements
- R1: After an accepted `start`, the first read is address 0 and the second is address 1. Each `rd_req` lasts exactly one cycle, and no new request is issued until the previous one has been acknowledged.
- R2: If status bit 2 (link) reads 0, address 1 is read a second time and `link_up` comes from that second read. If it reads 1, there is no second status read. Bit 5 (autonegotiation complete) is taken from the last status read.
- R3: When control bit 12 (autonegotiation enable) is 0, the block is in forced mode. Duplex is valid and equals control bit 8. Speed is 1000 if control bit 6 is set, otherwise 100 if control bit 13 is set, otherwise 10. Pause is none, and no register beyond the status register is read.
- R4: When autonegotiation is enabled and status bit 5 is 1, address 28 is read. Duplex is bit 5 of that word. Its bits 4:3 give the speed: 0 means 10, 1 means 100, and 2 or 3 mean 1000.
- R5: `spd` encodes 2'b00 for 10, 2'b01 for 100 and 2'b10 for 1000. It is qualified by `spd_valid` and is never 2'b11 while valid.
- R6: When autonegotiation is enabled but status bit 5 is 0, `spd_valid`, `dx_valid` and both pause flags are 0, and no read follows the status read(s).
- R7: Pause is resolved only when an autonegotiated result is full duplex. In that case address 5 (partner) is read and then address 4 (local). Half duplex, forced mode, and ability words that match no rule below all give no pause.
- R8: If partner bit 10 and local bit 10 (symmetric pause) are both set, both `pause_rx` and `pause_tx` are 1.
- R9: Otherwise, if partner bits 10 and 11 are both set and local bit 11 (asymmetric pause) is set, only `pause_tx` is 1. Otherwise, if partner bit 11 and local bit 10 are set, only `pause_rx` is 1.
- R10: A read acknowledged with `rd_err` ends the resolution at once. `done` rises with `err`=1 and all result outputs at 0, and no further read is issued.
- R11: `done` is a one-cycle pulse. The results change only in the cycle where `done` is high and then hold. A `start` that arrives while a resolution is in progress is ignored.
- R12: After reset, `done`, `err`, `rd_req` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a resolution |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Register address of the request |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | DATA_W | Read response data |
| rd_err | input | 1 | Read failed; valid with rd_ack |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Last resolution aborted on a read error |
| link_up | output | 1 | Link is up |
| spd_valid | output | 1 | Speed is known |
| spd | output | 2 | Speed code: 00=10, 01=100, 10=1000 |
| dx_valid | output | 1 | Duplex is known |
| full_dx | output | 1 | Full duplex |
| pause_rx | output | 1 | Receive pause enabled |
| pause_tx | output | 1 | Transmit pause enabled |

## Verification
A request appears in the cycle after `start` is sampled, and each later request appears in the cycle after the acknowledge of the previous one. `done` and the registered results appear two clock edges after the final acknowledge: one edge moves the sequencer into its finish state and the next edge loads the outputs. The bench changes stimulus only on falling edges. It polls for `done` on falling edges and compares every result and the logged address order at the falling edge where `done` is first seen. It then looks again three falling edges later to confirm that the results have held, that `done` has dropped and that no stray read was issued. The responder varies its acknowledge delay from run to run, so the checks depend on the handshake and not on a fixed cycle count.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_FIN
   } seq_state_t;

   typedef enum logic [2:0] {
      RD_CTL,
      RD_STS,
      RD_STS2,
      RD_AUX,
      RD_LPA,
      RD_ADV
   } rd_step_t;

   // capture slots, one per distinct register read
   localparam int unsigned NSLOT  = 5;
   localparam int unsigned SL_CTL = 0;
   localparam int unsigned SL_STS = 1;
   localparam int unsigned SL_AUX = 2;
   localparam int unsigned SL_LPA = 3;
   localparam int unsigned SL_ADV = 4;

   localparam logic [1:0] SPD_10   = 2'b00;
   localparam logic [1:0] SPD_100  = 2'b01;
   localparam logic [1:0] SPD_1000 = 2'b10;

   typedef struct packed {
      logic       link_up;
      logic       spd_valid;
      logic [1:0] spd;
      logic       dx_valid;
      logic       full_dx;
      logic       pause_rx;
      logic       pause_tx;
   } link_res_t;

   function automatic int unsigned slot_of(rd_step_t s);
      case (s)
         RD_CTL:           return SL_CTL;
         RD_STS, RD_STS2:  return SL_STS;
         RD_AUX:           return SL_AUX;
         RD_LPA:           return SL_LPA;
         default:          return SL_ADV;
      endcase
   endfunction

endpackage

// File: rtl/lnk_rd_seq.sv
module lnk_rd_seq
   import lnk_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned ADDR_CTL    = 0,
   parameter int unsigned ADDR_STS    = 1,
   parameter int unsigned ADDR_AUX    = 28,
   parameter int unsigned ADDR_LPA    = 5,
   parameter int unsigned ADDR_ADV    = 4,
   parameter int unsigned CTL_AN_EN   = 12,
   parameter int unsigned STS_LINK    = 2,
   parameter int unsigned STS_AN_DONE = 5,
   parameter int unsigned AUX_FDX     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_err,
   output logic              fin,
   output logic              fail,
   output logic [DATA_W-1:0] cap [NSLOT]
);

   seq_state_t st_q;
   rd_step_t   step_q;
   rd_step_t   step_nx;
   logic       last_rd;
   logic       fail_q;
   logic       accept;

   assign accept = (st_q == ST_WAIT) && rd_ack;

   // choose the following read from the word just returned
   always_comb begin
      step_nx = step_q;
      last_rd = 1'b0;
      unique case (step_q)
         RD_CTL: step_nx = RD_STS;
         RD_STS, RD_STS2: begin
            if ((step_q == RD_STS) && !rd_data[STS_LINK])
               step_nx = RD_STS2;
            else if (!cap[SL_CTL][CTL_AN_EN])
               last_rd = 1'b1;
            else if (rd_data[STS_AN_DONE])
               step_nx = RD_AUX;
            else
               last_rd = 1'b1;
         end
         RD_AUX: begin
            if (rd_data[AUX_FDX]) step_nx = RD_LPA;
            else                  last_rd = 1'b1;
         end
         RD_LPA:  step_nx = RD_ADV;
         default: last_rd = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         step_q <= RD_CTL;
         fail_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               st_q   <= ST_ISSUE;
               step_q <= RD_CTL;
               fail_q <= 1'b0;
            end
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: if (rd_ack) begin
               if (rd_err) begin
                  fail_q <= 1'b1;
                  st_q   <= ST_FIN;
               end else if (last_rd) begin
                  st_q   <= ST_FIN;
               end else begin
                  step_q <= step_nx;
                  st_q   <= ST_ISSUE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < NSLOT; g++) begin : g_cap
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (accept && !rd_err && (slot_of(step_q) == g))
            word_q <= rd_data;
      end
      assign cap[g] = word_q;
   end

   always_comb begin
      case (step_q)
         RD_CTL:          rd_addr = ADDR_W'(ADDR_CTL);
         RD_STS, RD_STS2: rd_addr = ADDR_W'(ADDR_STS);
         RD_AUX:          rd_addr = ADDR_W'(ADDR_AUX);
         RD_LPA:          rd_addr = ADDR_W'(ADDR_LPA);
         default:         rd_addr = ADDR_W'(ADDR_ADV);
      endcase
   end

   assign rd_req = (st_q == ST_ISSUE);
   assign fin    = (st_q == ST_FIN);
   assign fail   = fail_q;

endmodule

// File: rtl/lnk_mode_dec.sv
module lnk_mode_dec
   import lnk_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CTL_AN_EN   = 12,
   parameter int unsigned CTL_FDX     = 8,
   parameter int unsigned CTL_SPD_HI  = 6,
   parameter int unsigned CTL_SPD_LO  = 13,
   parameter int unsigned STS_LINK    = 2,
   parameter int unsigned STS_AN_DONE = 5,
   parameter int unsigned AUX_FDX     = 5,
   parameter int unsigned AUX_SPD_LO  = 3
) (
   input  logic [DATA_W-1:0] ctl_w,
   input  logic [DATA_W-1:0] sts_w,
   input  logic [DATA_W-1:0] aux_w,
   output logic              link_up,
   output logic              spd_valid,
   output logic [1:0]        spd,
   output logic              dx_valid,
   output logic              full_dx,
   output logic              pause_ok
);

   logic [1:0] aux_code;
   assign aux_code = aux_w[AUX_SPD_LO +: 2];

   always_comb begin
      link_up   = sts_w[STS_LINK];
      spd_valid = 1'b0;
      spd       = SPD_10;
      dx_valid  = 1'b0;
      full_dx   = 1'b0;
      pause_ok  = 1'b0;
      if (!ctl_w[CTL_AN_EN]) begin
         spd_valid = 1'b1;
         dx_valid  = 1'b1;
         full_dx   = ctl_w[CTL_FDX];
         if (ctl_w[CTL_SPD_HI])      spd = SPD_1000;
         else if (ctl_w[CTL_SPD_LO]) spd = SPD_100;
      end else if (sts_w[STS_AN_DONE]) begin
         spd_valid = 1'b1;
         dx_valid  = 1'b1;
         full_dx   = aux_w[AUX_FDX];
         pause_ok  = aux_w[AUX_FDX];
         case (aux_code)
            2'd0:    spd = SPD_10;
            2'd1:    spd = SPD_100;
            default: spd = SPD_1000;
         endcase
      end
   end

   logic unused_dec;
   assign unused_dec = ^{ctl_w, sts_w, aux_w};

endmodule

// File: rtl/lnk_pause_res.sv
module lnk_pause_res #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ABL_SYM  = 10,
   parameter int unsigned ABL_ASYM = 11
) (
   input  logic [DATA_W-1:0] lpa_w,
   input  logic [DATA_W-1:0] adv_w,
   input  logic              en,
   output logic              rx,
   output logic              tx
);

   logic lp_s, lp_a, lo_s, lo_a;
   assign lp_s = lpa_w[ABL_SYM];
   assign lp_a = lpa_w[ABL_ASYM];
   assign lo_s = adv_w[ABL_SYM];
   assign lo_a = adv_w[ABL_ASYM];

   always_comb begin
      rx = 1'b0;
      tx = 1'b0;
      if (en) begin
         if (lp_s && lo_s) begin
            rx = 1'b1;
            tx = 1'b1;
         end else if (lp_s && lp_a && lo_a) begin
            tx = 1'b1;
         end else if (lp_a && lo_s) begin
            rx = 1'b1;
         end
      end
   end

   logic unused_pause;
   assign unused_pause = ^{lpa_w, adv_w};

endmodule

// File: rtl/phy_link_resolver.sv
module phy_link_resolver
   import lnk_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned ADDR_CTL    = 0,
   parameter int unsigned ADDR_STS    = 1,
   parameter int unsigned ADDR_AUX    = 28,
   parameter int unsigned ADDR_LPA    = 5,
   parameter int unsigned ADDR_ADV    = 4,
   parameter int unsigned CTL_AN_EN   = 12,
   parameter int unsigned CTL_FDX     = 8,
   parameter int unsigned CTL_SPD_HI  = 6,
   parameter int unsigned CTL_SPD_LO  = 13,
   parameter int unsigned STS_LINK    = 2,
   parameter int unsigned STS_AN_DONE = 5,
   parameter int unsigned AUX_FDX     = 5,
   parameter int unsigned AUX_SPD_LO  = 3,
   parameter int unsigned ABL_SYM     = 10,
   parameter int unsigned ABL_ASYM    = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_err,
   output logic              done,
   output logic              err,
   output logic              link_up,
   output logic              spd_valid,
   output logic [1:0]        spd,
   output logic              dx_valid,
   output logic              full_dx,
   output logic              pause_rx,
   output logic              pause_tx
);

   localparam int unsigned MAX_BIT  = DATA_W - 1;
   localparam int unsigned ADDR_LIM = 1 << ADDR_W;

   // elaboration-time parameter checks
   if (CTL_AN_EN > MAX_BIT || CTL_FDX > MAX_BIT || CTL_SPD_HI > MAX_BIT ||
       CTL_SPD_LO > MAX_BIT || STS_LINK > MAX_BIT || STS_AN_DONE > MAX_BIT ||
       AUX_FDX > MAX_BIT || AUX_SPD_LO + 1 > MAX_BIT ||
       ABL_SYM > MAX_BIT || ABL_ASYM > MAX_BIT) begin : g_bad_bit
      $error("phy_link_resolver: a field position lies outside DATA_W");
   end
   if (ADDR_CTL >= ADDR_LIM || ADDR_STS >= ADDR_LIM || ADDR_AUX >= ADDR_LIM ||
       ADDR_LPA >= ADDR_LIM || ADDR_ADV >= ADDR_LIM) begin : g_bad_addr
      $error("phy_link_resolver: a register address does not fit ADDR_W");
   end

   logic              fin;
   logic              fail;
   logic [DATA_W-1:0] cap [NSLOT];
   logic              pause_ok;
   link_res_t         dec_res;
   link_res_t         res_q;
   logic              done_q;
   logic              err_q;

   lnk_rd_seq #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .ADDR_CTL(ADDR_CTL), .ADDR_STS(ADDR_STS), .ADDR_AUX(ADDR_AUX),
      .ADDR_LPA(ADDR_LPA), .ADDR_ADV(ADDR_ADV),
      .CTL_AN_EN(CTL_AN_EN), .STS_LINK(STS_LINK),
      .STS_AN_DONE(STS_AN_DONE), .AUX_FDX(AUX_FDX)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
      .fin(fin), .fail(fail), .cap(cap)
   );

   lnk_mode_dec #(
      .DATA_W(DATA_W), .CTL_AN_EN(CTL_AN_EN), .CTL_FDX(CTL_FDX),
      .CTL_SPD_HI(CTL_SPD_HI), .CTL_SPD_LO(CTL_SPD_LO),
      .STS_LINK(STS_LINK), .STS_AN_DONE(STS_AN_DONE),
      .AUX_FDX(AUX_FDX), .AUX_SPD_LO(AUX_SPD_LO)
   ) u_dec (
      .ctl_w(cap[SL_CTL]), .sts_w(cap[SL_STS]), .aux_w(cap[SL_AUX]),
      .link_up(dec_res.link_up), .spd_valid(dec_res.spd_valid),
      .spd(dec_res.spd), .dx_valid(dec_res.dx_valid),
      .full_dx(dec_res.full_dx), .pause_ok(pause_ok)
   );

   lnk_pause_res #(
      .DATA_W(DATA_W), .ABL_SYM(ABL_SYM), .ABL_ASYM(ABL_ASYM)
   ) u_pause (
      .lpa_w(cap[SL_LPA]), .adv_w(cap[SL_ADV]), .en(pause_ok),
      .rx(dec_res.pause_rx), .tx(dec_res.pause_tx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= fin;
         if (fin) begin
            res_q <= fail ? '0 : dec_res;
            err_q <= fail;
         end
      end
   end

   assign done      = done_q;
   assign err       = err_q;
   assign link_up   = res_q.link_up;
   assign spd_valid = res_q.spd_valid;
   assign spd       = res_q.spd;
   assign dx_valid  = res_q.dx_valid;
   assign full_dx   = res_q.full_dx;
   assign pause_rx  = res_q.pause_rx;
   assign pause_tx  = res_q.pause_tx;

endmodule

// File: rtl/lnk_chk.sv
module lnk_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_req,
   input logic       rd_ack,
   input logic       done,
   input logic       err,
   input logic       link_up,
   input logic       spd_valid,
   input logic [1:0] spd,
   input logic       dx_valid,
   input logic       full_dx,
   input logic       pause_rx,
   input logic       pause_tx
);

   logic out_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_q <= 1'b0;
      else if (rd_req) out_q <= 1'b1;
      else if (rd_ack) out_q <= 1'b0;
   end

   // R1
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R1
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !out_q);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({err, link_up, spd_valid, spd, dx_valid, full_dx, pause_rx, pause_tx}));

   // R10
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> !(link_up || spd_valid || dx_valid || pause_rx || pause_tx));

   // R5
   spd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spd_valid |-> (spd != 2'b11));

   // R7
   pause_fdx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_rx || pause_tx) |-> (dx_valid && full_dx));

endmodule

bind phy_link_resolver lnk_chk u_lnk_chk (
   .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
   .done(done), .err(err), .link_up(link_up), .spd_valid(spd_valid),
   .spd(spd), .dx_valid(dx_valid), .full_dx(full_dx),
   .pause_rx(pause_rx), .pause_tx(pause_tx)
);

// File: tb/tb_phy_link_resolver.sv
`timescale 1ns/1ps
module tb_phy_link_resolver;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rd_req;
   logic [4:0]  rd_addr;
   logic        rd_ack = 1'b0;
   logic [15:0] rd_data = '0;
   logic        rd_err = 1'b0;
   logic        done, err, link_up, spd_valid, dx_valid, full_dx, pause_rx, pause_tx;
   logic [1:0]  spd;

   always #2.5 clk = ~clk;

   phy_link_resolver dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
      .done(done), .err(err), .link_up(link_up), .spd_valid(spd_valid),
      .spd(spd), .dx_valid(dx_valid), .full_dx(full_dx),
      .pause_rx(pause_rx), .pause_tx(pause_tx)
   );

   int checks = 0;
   int fails  = 0;
   int runs   = 0;

   // responder configuration
   logic [15:0] cfg_ctl, cfg_sts1, cfg_sts2, cfg_aux, cfg_lpa, cfg_adv;
   int err_at = -1;
   int lat = 0;
   int base = 0;
   int log_total = 0;
   int log_a [1024];
   int pend = 0;
   int cnt = 0;
   logic [15:0] p_data = '0;
   logic p_err = 1'b0;

   // read responder: answers each request at least one falling edge later
   always @(negedge clk) begin
      rd_ack = 1'b0;
      rd_err = 1'b0;
      if (pend != 0) begin
         if (cnt == 0) begin
            rd_ack  = 1'b1;
            rd_data = p_data;
            rd_err  = p_err;
            pend    = 0;
         end else begin
            cnt = cnt - 1;
         end
      end
      if (rd_req) begin
         int idx;
         idx = log_total - base;
         if (log_total < 1024) log_a[log_total] = int'(rd_addr);
         log_total = log_total + 1;
         case (rd_addr)
            5'd0:    p_data = cfg_ctl;
            5'd1:    p_data = (idx <= 1) ? cfg_sts1 : cfg_sts2;
            5'd28:   p_data = cfg_aux;
            5'd5:    p_data = cfg_lpa;
            5'd4:    p_data = cfg_adv;
            default: p_data = 16'hDEAD;
         endcase
         p_err = (idx == err_at);
         pend  = 1;
         cnt   = lat;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] outvec();
      return {err, link_up, spd_valid, spd, dx_valid, full_dx, pause_rx};
   endfunction

   task automatic run(input logic [15:0] c, input logic [15:0] s1, input logic [15:0] s2,
                      input logic [15:0] a, input logic [15:0] l, input logic [15:0] v,
                      input int e_at, input bit restart);
      int eseq [8];
      int en;
      int w;
      logic [15:0] s_last;
      bit e_link, e_sv, e_dv, e_fd, e_rx, e_tx, e_err, same;
      logic [1:0] e_spd;
      string path, ptag;
      logic [8:0] snap;
      int tot0;

      // expected behaviour, from the requirements
      en = 0; eseq[en] = 0; en++; eseq[en] = 1; en++;
      if (!s1[2]) begin eseq[en] = 1; en++; end            // R2
      s_last = s1[2] ? s1 : s2;
      e_link = s_last[2];
      e_sv = 0; e_dv = 0; e_fd = 0; e_spd = 2'b00; e_rx = 0; e_tx = 0; e_err = 0;
      ptag = "R7";
      if (!c[12]) begin                                     // R3 forced
         path = "R3";
         e_sv = 1; e_dv = 1; e_fd = c[8];
         e_spd = c[6] ? 2'b10 : (c[13] ? 2'b01 : 2'b00);
      end else if (s_last[5]) begin                          // R4
         path = "R4";
         eseq[en] = 28; en++;
         e_sv = 1; e_dv = 1; e_fd = a[5];
         e_spd = (a[4:3] == 2'd0) ? 2'b00 : ((a[4:3] == 2'd1) ? 2'b01 : 2'b10);
         if (a[5]) begin                                     // R7
            eseq[en] = 5; en++; eseq[en] = 4; en++;
            if (l[10] && v[10]) begin e_rx = 1; e_tx = 1; ptag = "R8"; end
            else if (l[10] && l[11] && v[11]) begin e_tx = 1; ptag = "R9"; end
            else if (l[11] && v[10]) begin e_rx = 1; ptag = "R9"; end
         end
      end else begin
         path = "R6";
      end
      if (e_at >= 0 && e_at < en) begin                       // R10
         en = e_at + 1;
         e_link = 0; e_sv = 0; e_dv = 0; e_fd = 0; e_spd = 2'b00; e_rx = 0; e_tx = 0;
         e_err = 1; path = "R10"; ptag = "R10";
      end

      @(negedge clk);
      cfg_ctl = c; cfg_sts1 = s1; cfg_sts2 = s2; cfg_aux = a; cfg_lpa = l; cfg_adv = v;
      err_at = e_at; lat = runs % 4; runs++;
      base = log_total;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (restart) begin
         @(negedge clk);
         start = 1'b1;                                        // R11 ignored while busy
         @(negedge clk);
         start = 1'b0;
      end
      w = 0;
      while (!done && w < 200) begin
         @(negedge clk);
         w++;
      end
      chk(done, "R11", "done seen", int'(done), 1);
      chk(err == e_err, "R10", "err flag", int'(err), int'(e_err));
      chk(link_up == e_link, "R2", "link_up", int'(link_up), int'(e_link));
      chk(spd_valid == e_sv, path, "speed valid", int'(spd_valid), int'(e_sv));
      if (e_sv) chk(spd == e_spd, path, "speed code (R5)", int'(spd), int'(e_spd));
      chk(dx_valid == e_dv, path, "duplex valid", int'(dx_valid), int'(e_dv));
      chk(full_dx == e_fd, path, "full duplex", int'(full_dx), int'(e_fd));
      chk({pause_rx, pause_tx} == {e_rx, e_tx}, ptag, "pause rx/tx",
          int'({pause_rx, pause_tx}), int'({e_rx, e_tx}));
      same = (log_total - base) == en;
      for (int i = 0; i < en; i++)
         if (same && log_a[base + i] != eseq[i]) same = 0;
      chk(same, "R1", "read address order (count)", log_total - base, en);

      snap = {outvec(), pause_tx};
      tot0 = log_total;
      repeat (3) @(negedge clk);
      chk(!done && ({outvec(), pause_tx} == snap) && (log_total == tot0), "R11",
          "results hold after done", int'({outvec(), pause_tx}), int'(snap));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R11 watchdog: actual 100000 cycles expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] c, s1, s2, a, l, v;
      cfg_ctl = '0; cfg_sts1 = '0; cfg_sts2 = '0; cfg_aux = '0; cfg_lpa = '0; cfg_adv = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(({outvec(), pause_tx} == 9'd0) && !rd_req && !done, "R12", "reset state",
          int'({outvec(), pause_tx, rd_req, done}), 0);

      // R3 forced mode, with every link pattern of R2
      for (int fd = 0; fd < 2; fd++)
         for (int sp = 0; sp < 4; sp++)
            for (int lk = 0; lk < 3; lk++) begin
               c = '0; c[8] = fd[0]; c[6] = sp[1]; c[13] = sp[0];
               s1 = 16'h0020; s1[2] = (lk == 0);
               s2 = 16'h0020; s2[2] = (lk == 2);
               run(c, s1, s2, 16'h0038, 16'h0C00, 16'h0C00, -1, 1'b0);
            end

      // R6 autonegotiation not complete
      for (int lk = 0; lk < 3; lk++) begin
         c = 16'h1000;
         s1 = '0; s1[2] = (lk == 0);
         s2 = '0; s2[2] = (lk == 2);
         run(c, s1, s2, 16'h0038, 16'h0C00, 16'h0C00, -1, 1'b0);
      end

      // R4 auxiliary decode, R7..R9 pause resolution
      for (int code = 0; code < 4; code++)
         for (int fdx = 0; fdx < 2; fdx++)
            for (int pm = 0; pm < (fdx != 0 ? 16 : 1); pm++) begin
               c = 16'h1000;
               a = '0; a[4:3] = code[1:0]; a[5] = fdx[0];
               l = '0; l[10] = pm[0]; l[11] = pm[1];
               v = '0; v[10] = pm[2]; v[11] = pm[3];
               if (fdx == 0) begin l = 16'h0C00; v = 16'h0C00; end
               run(c, 16'h0024, 16'h0024, a, l, v, -1, 1'b0);
            end

      // R10 error at each position of the longest sequence
      for (int e = 0; e < 6; e++)
         run(16'h1000, 16'h0020, 16'h0024, 16'h0028, 16'h0400, 16'h0400, e, 1'b0);

      // R11 second start while busy
      lat = 3;
      run(16'h1000, 16'h0020, 16'h0024, 16'h0030, 16'h0C00, 16'h0800, -1, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule